// File: doc/BRIEF.md
# SPI NAND Page Program and Block Erase Sequencer

This block drives a serial NAND device over a four-wire SPI link (mode 0) to carry out two long operations. The first writes a byte stream into the array, starting at any byte address. The second erases a run of consecutive erase blocks. A host hands over one command, which gives the operation, a start address or start block, and a length in bytes or blocks. For programming it then supplies the data bytes on a valid/ready stream. When the work ends the block raises a one-cycle completion pulse with the number of bytes or blocks that were finished.

Programming is split into chunks so that no chunk runs past the end of a 2048-byte page. For each chunk the sequencer fills the device's cache with a load frame, then opens writing with a separate enable frame, then commits the page with an execute frame, and then reads status until the device is idle. Erasing repeats three steps for each block: an enable frame, an erase frame, and a status wait. Either operation halts as soon as the device reports its own failure bit: the program-fail bit for programming and the erase-fail bit for erasing. Before any of this work starts, the device is polled once until it reports idle.

Top module: `spinand_pe_engine`

## Requirements
- R1: After a command is accepted, the first SPI frames are status reads (bytes 0x0F, 0xC0, then one byte clocked in). A further status read follows as long as status bit 0 (busy) is 1. No other frame is sent before a status read returns bit 0 clear.
- R2: A cache-load frame sends 0x02, then the column offset (start address modulo 2048) as two bytes with the high byte first, then the chunk's data bytes in stream order.
- R3: A chunk holds min(bytes remaining, 2048 − column offset) bytes, so no chunk crosses a 2048-byte page boundary.
- R4: After each cache-load frame comes a one-byte frame 0x06. Next comes an execute frame: 0x10 and a 3-byte page index (byte address divided by 2048), high byte first. Status reads then repeat while bit 0 is 1.
- R5: If the status that ends a program wait has bit 3 set, programming stops. The reported count is the total bytes of the chunks that finished before the failing chunk.
- R6: For each block, erasing sends 0x06 in its own frame, then 0xD8 with a 3-byte row equal to the block index times 64, then status reads while bit 0 is 1.
- R7: If the status that ends an erase wait has bit 2 set, erasing stops. The reported count is the number of blocks erased before it.
- R8: done is high for exactly one cycle per command, and done_count is valid in that cycle. cmd_ready is low from acceptance until done, and a command presented in that time has no effect. A command held up during the done cycle is accepted at that cycle.
- R9: in_ready is high only together with in_valid, only inside a cache-load frame, and each such cycle consumes one byte. If the stream runs dry, chip select stays low and SCLK stops low until data returns.
- R10: SPI mode 0 applies. SCLK is low whenever chip select is high. MOSI is most significant bit first and holds steady while SCLK is high. Only whole bytes are sent in a frame, and chip select goes high for at least one cycle between frames.
- R11: A length of 0 produces only the initial status wait and then done with a count of 0.
- R12: After reset, chip select is high, SCLK is low, cmd_ready is high, and done and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; command taken when both are high |
| cmd_erase | input | 1 | 1 = erase blocks, 0 = program bytes |
| cmd_addr | input | ADDR_W (32) | Start byte address (program) or start block index (erase) |
| cmd_len | input | LEN_W (16) | Byte count (program) or block count (erase) |
| in_valid | input | 1 | Program data byte present |
| in_ready | output | 1 | Program data byte taken this cycle |
| in_data | input | 8 | Program data byte |
| spi_sclk | output | 1 | SPI clock, half the system clock rate |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | LEN_W (16) | Bytes programmed or blocks erased |

## Verification
The completion pulse and the acceptance of the next command can fall in the same cycle, because the engine frees itself in the very cycle it signals done. The bench provokes this by holding a second command valid for the whole time the first one runs, with different fields. It then judges that the first command's frame list is unchanged, that cmd_ready stayed low in between, and that the second command's frames follow directly on the first's. A second overlap is a stream stall that lands in the middle of a cache-load frame. The SCLK edges and the chip-select level counted during that stall must show that the frame was held open, not ended.

// File: rtl/spinand_pe_pkg.sv
// Package: shared command bytes, status masks and sequencer types for the
// SPI NAND program/erase engine. Assumes the device's 8-bit command set.
package spinand_pe_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam logic [7:0] OPC_GET_STATUS = 8'h0F;
    localparam logic [7:0] REG_STATUS     = 8'hC0;
    localparam logic [7:0] OPC_LOAD       = 8'h02;
    localparam logic [7:0] OPC_WREN       = 8'h06;
    localparam logic [7:0] OPC_COMMIT     = 8'h10;
    localparam logic [7:0] OPC_ERASE      = 8'hD8;

    localparam logic [7:0] ST_BUSY_MASK   = 8'h01;
    localparam logic [7:0] ST_EFAIL_MASK  = 8'h04;
    localparam logic [7:0] ST_PFAIL_MASK  = 8'h08;

    typedef enum logic [2:0] {
        FR_NONE, FR_POLL, FR_LOAD, FR_WREN, FR_COMMIT, FR_ERASE
    } frame_e;

    typedef enum logic [1:0] {
        WAIT_START, WAIT_PROG, WAIT_ERASE
    } wait_e;
endpackage

// File: rtl/spinand_byte_shifter.sv
// Module: one SPI mode-0 byte transfer per start pulse. Each bit costs two
// clocks: SCLK low while MOSI settles, then SCLK high with MISO sampled.
// Assumes start is raised only while idle is high.
module spinand_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              idle,
    output logic [BYTE_W-1:0] rx_byte
);
    timeunit 1ns; timeprecision 1ps;

    localparam int CNT_W = $clog2(BYTE_W);

    logic              busy_q;
    logic              sclk_q;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] rx_q;

    // Bit sequencer: load, raise SCLK and sample, lower SCLK and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            sh_q   <= tx_byte;
        end else if (busy_q) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[BYTE_W-2:0], miso};
            end else begin
                sclk_q <= 1'b0;
                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                bit_q  <= bit_q + 1'b1;
                if (bit_q == CNT_W'(BYTE_W - 1)) busy_q <= 1'b0;
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = sh_q[BYTE_W-1];
    assign idle    = !busy_q;
    assign rx_byte = rx_q;
endmodule

// File: rtl/spinand_chunk_plan.sv
// Module: size of the next program chunk, the smaller of the bytes left and
// the room up to the end of the current page. Assumes LEN_W > log2(page).
module spinand_chunk_plan #(
    parameter int PAGE_BYTES = 2048,
    parameter int LEN_W      = 16,
    localparam int COL_W     = $clog2(PAGE_BYTES)
) (
    input  logic [COL_W-1:0] col,
    input  logic [LEN_W-1:0] remaining,
    output logic [LEN_W-1:0] chunk
);
    timeunit 1ns; timeprecision 1ps;

    logic [LEN_W:0] room;

    // Room left in the page, then clip the request to it.
    always_comb begin
        room  = (LEN_W+1)'(PAGE_BYTES) - (LEN_W+1)'(col);
        chunk = ({1'b0, remaining} < room) ? remaining : LEN_W'(room);
    end
endmodule

// File: rtl/spinand_pe_engine.sv
// Module: SPI NAND program/erase sequencer. Polls the device idle, then
// runs load/enable/commit/wait per page chunk, or enable/erase/wait per
// block, and stops on the matching fail bit. Assumes ADDR_W >= 8*ROW_BYTES
// and a page no larger than 64 KiB.
module spinand_pe_engine
    import spinand_pe_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int LEN_W           = 16,
    parameter int PAGE_BYTES      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int ROW_BYTES       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              done,
    output logic [LEN_W-1:0]  done_count
);
    timeunit 1ns; timeprecision 1ps;

    localparam int COL_W     = $clog2(PAGE_BYTES);
    localparam int BLK_SHIFT = $clog2(PAGES_PER_BLOCK);
    localparam int ROW_W     = 8 * ROW_BYTES;
    localparam int IDX_W     = LEN_W + 1;
    localparam int HDR_LOAD  = 3;

    frame_e            frame_q;
    wait_e             wait_q;
    logic              busy_q, cs_n_q, done_q, erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q, count_q, chunk;
    logic [IDX_W-1:0]  idx_q, flen;
    logic [7:0]        tx, rx, row_byte;
    logic [ROW_W-1:0]  row;
    logic [15:0]       col16;
    logic              data_phase, frame_on, sh_idle, can_issue, frame_end;
    logic              st_busy, st_pfail, st_efail;

    spinand_chunk_plan #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_plan (
        .col(addr_q[COL_W-1:0]), .remaining(rem_q), .chunk(chunk)
    );

    spinand_byte_shifter #(.BYTE_W(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(can_issue), .tx_byte(tx),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .idle(sh_idle), .rx_byte(rx)
    );

    // Row address: page index for commit, block index scaled for erase.
    always_comb begin
        if (erase_q) row = ROW_W'({addr_q, {BLK_SHIFT{1'b0}}});
        else         row = ROW_W'(addr_q >> COL_W);
        row_byte = 8'(row >> (8 * (ROW_BYTES - int'(idx_q))));
        col16    = 16'(addr_q[COL_W-1:0]);
    end

    // Frame contents: byte to send at the current index and frame length.
    always_comb begin
        tx         = 8'h00;
        flen       = '0;
        data_phase = 1'b0;
        case (frame_q)
            FR_POLL: begin
                flen = IDX_W'(3);
                if (idx_q == IDX_W'(0))      tx = OPC_GET_STATUS;
                else if (idx_q == IDX_W'(1)) tx = REG_STATUS;
            end
            FR_WREN: begin
                flen = IDX_W'(1);
                tx   = OPC_WREN;
            end
            FR_COMMIT, FR_ERASE: begin
                flen = IDX_W'(1 + ROW_BYTES);
                if (idx_q == IDX_W'(0)) tx = (frame_q == FR_ERASE) ? OPC_ERASE : OPC_COMMIT;
                else                    tx = row_byte;
            end
            FR_LOAD: begin
                flen = IDX_W'(HDR_LOAD) + IDX_W'(chunk);
                if (idx_q == IDX_W'(0))      tx = OPC_LOAD;
                else if (idx_q == IDX_W'(1)) tx = col16[15:8];
                else if (idx_q == IDX_W'(2)) tx = col16[7:0];
                else begin
                    tx         = in_data;
                    data_phase = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Byte issue and frame end qualifiers; a dry stream simply waits.
    always_comb begin
        frame_on  = !cs_n_q && (frame_q != FR_NONE);
        can_issue = frame_on && sh_idle && (idx_q < flen) && (!data_phase || in_valid);
        frame_end = frame_on && sh_idle && (idx_q == flen);
        st_busy   = |(rx & ST_BUSY_MASK);
        st_pfail  = |(rx & ST_PFAIL_MASK);
        st_efail  = |(rx & ST_EFAIL_MASK);
    end

    // Sequencer: accept, select, issue bytes, then choose the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            erase_q <= 1'b0;
            frame_q <= FR_NONE;
            wait_q  <= WAIT_START;
            idx_q   <= '0;
            addr_q  <= '0;
            rem_q   <= '0;
            count_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (cmd_valid) begin
                    busy_q  <= 1'b1;
                    erase_q <= cmd_erase;
                    addr_q  <= cmd_addr;
                    rem_q   <= cmd_len;
                    count_q <= '0;
                    frame_q <= FR_POLL;
                    wait_q  <= WAIT_START;
                end
            end else if (cs_n_q) begin
                cs_n_q <= 1'b0;
                idx_q  <= '0;
            end else if (can_issue) begin
                idx_q <= idx_q + 1'b1;
            end else if (frame_end) begin
                cs_n_q <= 1'b1;
                case (frame_q)
                    FR_POLL: begin
                        if (!st_busy) begin
                            case (wait_q)
                                WAIT_START: begin
                                    if (rem_q == '0) begin
                                        frame_q <= FR_NONE; busy_q <= 1'b0; done_q <= 1'b1;
                                    end else begin
                                        frame_q <= erase_q ? FR_WREN : FR_LOAD;
                                    end
                                end
                                WAIT_PROG: begin
                                    if (st_pfail || rem_q == chunk) begin
                                        frame_q <= FR_NONE; busy_q <= 1'b0; done_q <= 1'b1;
                                    end else begin
                                        frame_q <= FR_LOAD;
                                    end
                                    if (!st_pfail) begin
                                        addr_q  <= addr_q + ADDR_W'(chunk);
                                        rem_q   <= rem_q - chunk;
                                        count_q <= count_q + chunk;
                                    end
                                end
                                default: begin
                                    if (st_efail || rem_q == LEN_W'(1)) begin
                                        frame_q <= FR_NONE; busy_q <= 1'b0; done_q <= 1'b1;
                                    end else begin
                                        frame_q <= FR_WREN;
                                    end
                                    if (!st_efail) begin
                                        addr_q  <= addr_q + 1'b1;
                                        rem_q   <= rem_q - 1'b1;
                                        count_q <= count_q + 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    FR_LOAD:   frame_q <= FR_WREN;
                    FR_WREN:   frame_q <= erase_q ? FR_ERASE : FR_COMMIT;
                    FR_COMMIT: begin frame_q <= FR_POLL; wait_q <= WAIT_PROG;  end
                    FR_ERASE:  begin frame_q <= FR_POLL; wait_q <= WAIT_ERASE; end
                    default:   frame_q <= FR_NONE;
                endcase
            end
        end
    end

    assign cmd_ready  = !busy_q;
    assign in_ready   = can_issue && data_phase;
    assign spi_cs_n   = cs_n_q;
    assign done       = done_q;
    assign done_count = count_q;
endmodule

// File: rtl/spinand_pe_checker.sv
// Module: protocol properties of the program/erase engine's ports, bound
// into every instance. Assumes synchronous active-low reset.
module spinand_pe_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic done,
    input logic in_valid,
    input logic in_ready,
    input logic spi_sclk,
    input logic spi_cs_n,
    input logic spi_mosi
);
    timeunit 1ns; timeprecision 1ps;

    // R10: the clock never moves while the device is deselected.
    assert_sclk_idle_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R10: data is steady across the high half of every bit.
    assert_mosi_steady_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    // R9: a byte is taken only when offered, and only inside a frame.
    assert_take_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (in_valid && !spi_cs_n));

    // R8: completion is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the engine is free again in the cycle it reports completion.
    assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);
endmodule

bind spinand_pe_engine spinand_pe_checker u_pe_checker (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/test_spinand_pe_engine.sv
// Bench: a behavioural serial NAND device records every frame, returns
// scripted status bytes, and the frame lists are compared with a list
// built from the requirements. Pin rules are checked every clock.
module test_spinand_pe_engine;
    timeunit 1ns; timeprecision 1ps;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_erase = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        spi_miso = 1'b0;
    wire         cmd_ready, in_ready, spi_sclk, spi_cs_n, spi_mosi, done;
    wire  [15:0] done_count;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spinand_pe_engine i_spinand_pe_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .done(done), .done_count(done_count)
    );

    task automatic check_eq(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    int         seen[$];
    int         status_q[$];
    bit         prev_sclk = 0, prev_cs = 1;
    logic [7:0] cur = '0, first = '0, out_sh = '0;
    int         bitn = 0, fbytes = 0;
    bit         out_on = 0;
    bit         in_stall = 0;
    int         stall_rises = 0, stall_cs_high = 0;

    always @(negedge clk) begin
        if (rst_n) check_eq("R10 sclk low while deselected", spi_cs_n && spi_sclk, 0);
        if (prev_cs && !spi_cs_n) begin
            bitn = 0; fbytes = 0; out_on = 0;
        end
        if (!spi_cs_n && !prev_sclk && spi_sclk) begin
            cur = {cur[6:0], spi_mosi};
            bitn++;
            if (in_stall) stall_rises++;
            if (bitn == 8) begin
                seen.push_back(int'(cur));
                if (fbytes == 0) first = cur;
                fbytes++;
                bitn = 0;
                if (fbytes == 2 && first == 8'h0F) begin
                    out_sh = (status_q.size() > 0) ? 8'(status_q.pop_front()) : 8'h00;
                    out_on = 1;
                end
            end
        end
        if (!spi_cs_n && prev_sclk && !spi_sclk && out_on) begin
            spi_miso = out_sh[7];
            out_sh   = {out_sh[6:0], 1'b0};
        end
        if (in_stall && spi_cs_n) stall_cs_high++;
        if (!prev_cs && spi_cs_n) begin
            check_eq("R10 whole bytes per frame", bitn, 0);
            seen.push_back(-1);
            spi_miso = 1'b0;
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs_n;
    end

    // ---------------- data stream source ----------------
    int data_q[$];
    int ref_q[$];
    int taken = 0, stall_at = -1, stall_len = 0, stall_left = 0;
    bit take = 0, stall_used = 0;

    always @(negedge clk) begin
        if (take) begin
            void'(data_q.pop_front());
            taken++;
            take = 0;
        end
        if (stall_left > 0) begin
            stall_left--;
            in_valid = 1'b0;
            in_stall = (stall_left > 0);
        end else if (taken == stall_at && !stall_used) begin
            stall_used = 1;
            stall_left = stall_len - 1;
            in_stall   = 1;
            in_valid   = 1'b0;
        end else if (data_q.size() > 0) begin
            in_valid = 1'b1;
            in_data  = 8'(data_q[0]);
        end else begin
            in_valid = 1'b0;
        end
        #1;
        take = in_valid && in_ready;
    end

    // ---------------- expected frame builders ----------------
    int exp_q[$];
    int ref_pos = 0;

    task automatic push_data(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            data_q.push_back((seed + 37 * i) & 8'hFF);
            ref_q.push_back((seed + 37 * i) & 8'hFF);
        end
    endtask

    task automatic e_poll(input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(8'h0F); exp_q.push_back(8'hC0);
            exp_q.push_back(8'h00); exp_q.push_back(-1);
        end
    endtask

    task automatic e_wren();
        exp_q.push_back(8'h06); exp_q.push_back(-1);
    endtask

    task automatic e_row(input int opc, input int row);
        exp_q.push_back(opc);
        exp_q.push_back((row >> 16) & 8'hFF);
        exp_q.push_back((row >> 8) & 8'hFF);
        exp_q.push_back(row & 8'hFF);
        exp_q.push_back(-1);
    endtask

    task automatic e_load(input int addr, input int n);
        exp_q.push_back(8'h02);
        exp_q.push_back(((addr % 2048) >> 8) & 8'hFF);
        exp_q.push_back((addr % 2048) & 8'hFF);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(ref_q[ref_pos]);
            ref_pos++;
        end
        exp_q.push_back(-1);
    endtask

    task automatic cmp_frames(input string tag);
        int bad;
        bad = -1;
        check_eq({tag, " frame byte total"}, seen.size(), exp_q.size());
        for (int i = 0; i < seen.size() && i < exp_q.size(); i++)
            if (bad < 0 && seen[i] != exp_q[i]) bad = i;
        if (bad >= 0) check_eq({tag, " frame contents"}, seen[bad], exp_q[bad]);
        else          check_eq({tag, " frame contents"}, 0, 0);
        seen.delete();
        exp_q.delete();
    endtask

    // ---------------- command helpers ----------------
    task automatic wait_done(output int cnt);
        int t;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check_eq("R8 done pulse seen", done, 1);
        cnt = int'(done_count);
        @(negedge clk);
        check_eq("R8 done lasts one cycle", done, 0);
    endtask

    task automatic run_cmd(input bit er, input int addr, input int len, output int cnt);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = er; cmd_addr = 32'(addr); cmd_len = 16'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        check_eq("R8 cmd_ready low while busy", cmd_ready, 0);
        wait_done(cnt);
    endtask

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check_eq("R12 cs_n after reset", spi_cs_n, 1);
        check_eq("R12 sclk after reset", spi_sclk, 0);
        check_eq("R12 cmd_ready after reset", cmd_ready, 1);
        check_eq("R12 done after reset", done, 0);
        check_eq("R12 in_ready after reset", in_ready, 0);

        // R1 R2 R3 R4: program across a page boundary with busy polls
        status_q = '{1, 0, 1, 0, 0};
        push_data(20, 8'h11);
        e_poll(2); e_load(8184, 8); e_wren(); e_row(8'h10, 3); e_poll(2);
        e_load(8192, 12); e_wren(); e_row(8'h10, 4); e_poll(1);
        run_cmd(0, 8184, 20, cnt);
        check_eq("R3 program count across page", cnt, 20);
        cmp_frames("R1 R2 R3 R4 split program");

        // R9: stream stall in the middle of a load frame
        stall_at = taken + 2; stall_len = 60; stall_used = 0;
        stall_rises = 0; stall_cs_high = 0;
        push_data(6, 8'h5A);
        e_poll(1); e_load(48, 6); e_wren(); e_row(8'h10, 0); e_poll(1);
        run_cmd(0, 48, 6, cnt);
        check_eq("R9 program count with stall", cnt, 6);
        check_eq("R9 stall happened", stall_used, 1);
        check_eq("R9 sclk held during stall", stall_rises <= 8, 1);
        check_eq("R9 cs held low during stall", stall_cs_high, 0);
        cmp_frames("R9 stalled program");

        // R5: program fail on the second chunk
        status_q = '{0, 0, 8};
        push_data(10, 8'h80);
        e_poll(1); e_load(2044, 4); e_wren(); e_row(8'h10, 0); e_poll(1);
        e_load(2048, 6); e_wren(); e_row(8'h10, 1); e_poll(1);
        run_cmd(0, 2044, 10, cnt);
        check_eq("R5 count stops at failed chunk", cnt, 4);
        cmp_frames("R5 program fail");

        // R6: erase three blocks with one busy poll
        status_q = '{0, 0, 1, 0, 0};
        e_poll(1); e_wren(); e_row(8'hD8, 320); e_poll(1);
        e_wren(); e_row(8'hD8, 384); e_poll(2);
        e_wren(); e_row(8'hD8, 448); e_poll(1);
        run_cmd(1, 5, 3, cnt);
        check_eq("R6 erase block count", cnt, 3);
        cmp_frames("R6 erase run");

        // R7: erase fail on the second block
        status_q = '{0, 0, 4};
        e_poll(1); e_wren(); e_row(8'hD8, 64); e_poll(1);
        e_wren(); e_row(8'hD8, 128); e_poll(1);
        run_cmd(1, 1, 4, cnt);
        check_eq("R7 count stops at failed block", cnt, 1);
        cmp_frames("R7 erase fail");

        // R11: zero length
        status_q = '{1, 0};
        e_poll(2);
        run_cmd(0, 100, 0, cnt);
        check_eq("R11 zero length count", cnt, 0);
        cmp_frames("R11 zero length");

        // R8: second command held valid while busy, taken at done
        status_q.delete();
        e_poll(1); e_wren(); e_row(8'hD8, 128); e_poll(1);
        e_poll(1); e_wren(); e_row(8'hD8, 576); e_poll(1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = 1'b1; cmd_addr = 32'd2; cmd_len = 16'd1;
        @(negedge clk);
        cmd_addr = 32'd9;
        repeat (20) @(negedge clk);
        check_eq("R8 busy ignores command", cmd_ready, 0);
        wait_done(cnt);
        check_eq("R8 first command count", cnt, 1);
        cmd_valid = 1'b0;
        check_eq("R8 second command taken at done", cmd_ready, 0);
        wait_done(cnt);
        check_eq("R8 second command count", cnt, 1);
        cmp_frames("R8 back to back");

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule